// File: doc/BRIEF.md
# CRC Accumulate Execution Unit

This unit sits in a processor datapath and executes a family of CRC update instructions. It receives a 32-bit instruction word, the current 32-bit CRC accumulator, a message operand and a valid strobe. It decodes the instruction to find how many operand bytes to fold in (1, 2, 4 or 8) and which polynomial to use: plain CRC-32 or the Castagnoli variant, CRC-32C. It then folds the bytes into the accumulator one per clock, least significant byte first. When it finishes it returns the new accumulator and the register index that receives it, and pulses done.

Both polynomials are applied in reflected form, with the bit shifted out at the LSB end. The unit applies no initial or final inversion. Software presets the accumulator and complements the final value itself. A word that is not a CRC instruction is answered at once with an illegal flag, and the accumulator is returned unchanged. A parameter sets the datapath width. At 32 bits the eight-byte form is also rejected as illegal.

Top module: `crc_exec_unit`

## Requirements
- R1: An instruction is legal only if `(instr & 32'hFC00FE3F) == 32'h7C00000F`. On an accepted illegal word, `illegal_o` and `done_o` are both high in the cycle after the accepting edge, and `acc_o` equals the `acc_i` value that was sampled at that edge.
- R2: `rd_o` carries instruction bits 20:16 of the accepted instruction and holds that value until the next acceptance. Bits 25:21, the operand register index, have no effect on any output.
- R3: The size field in bits 7:6 selects the byte count: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. Operand bytes above the selected count have no effect on the result.
- R4: Bit 8 selects the polynomial. A 0 selects reflected 0xEDB88320 (CRC-32) and a 1 selects reflected 0x82F63B78 (CRC-32C).
- R5: Operand bytes are folded in starting from bits 7:0 and moving upward. For each byte the accumulator is XORed with the byte in its low 8 bits, then shifted right 8 times, XORing in the polynomial whenever the bit shifted out is 1. No inversion is applied.
- R6: For a legal instruction of N bytes, `done_o` is high exactly N cycles after the cycle following the accepting edge, and it lasts one cycle per operation. `illegal_o` stays low throughout.
- R7: When the datapath width parameter is 32, a legal-pattern word with size code 3 is reported as illegal. At width 64 the same word is executed.
- R8: A valid strobe that arrives while an operation is in progress is ignored. It does not affect the result, `rd_o` or the latency, and it produces no extra done.
- R9: A valid strobe in the same cycle as `done_o` is accepted as a new operation.
- R10: After reset, `done_o` and `illegal_o` are 0, and `acc_o` and `rd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue strobe for the instruction |
| instr_i | input | 32 | Instruction word |
| acc_i | input | 32 | Current CRC accumulator value |
| operand_i | input | XLEN | Message operand, little-endian |
| acc_o | output | 32 | Updated accumulator |
| rd_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Instruction rejected |
| done_o | output | 1 | Result valid, one-cycle pulse |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. The bench raises valid during the cycle in which the first operation's done is visible. It then checks that the first result is correct in that cycle and that the second operation finishes with its own expected value and latency. The bench also issues a strobe in the middle of a running eight-byte operation and judges it by the unchanged result, index and latency, and by the absence of a second done pulse.

// File: rtl/crcu_pkg.sv
package crcu_pkg;
  localparam int unsigned CRC_W = 32;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned CNT_W = 4;

  localparam logic [31:0] OPC_PATTERN = 32'h7C00000F;
  localparam logic [31:0] OPC_MASK    = 32'hFC00FE3F;

  localparam logic [CRC_W-1:0] POLY_STD  = 32'hEDB88320;
  localparam logic [CRC_W-1:0] POLY_CAST = 32'h82F63B78;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } crcu_state_e;

  typedef struct packed {
    logic             legal;
    logic             cast;
    logic [CNT_W-1:0] nbytes;
    logic [IDX_W-1:0] rt;
  } crcu_dec_t;
endpackage

// File: rtl/crcu_rst_sync.sv
module crcu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/crcu_decode.sv
module crcu_decode
  import crcu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [31:0] instr,
  output crcu_dec_t   dec
);
  logic       pattern_ok;
  logic [1:0] size_code;
  logic       size_ok;

  assign pattern_ok = ((instr & OPC_MASK) == OPC_PATTERN);
  assign size_code  = instr[7:6];

  generate
    if (XLEN >= 64) begin : g_wide
      assign size_ok = 1'b1;
    end else begin : g_narrow
      assign size_ok = (size_code != 2'd3);
    end
  endgenerate

  always_comb begin
    dec.legal  = pattern_ok && size_ok;
    dec.cast   = instr[8];
    dec.rt     = instr[20:16];
    dec.nbytes = CNT_W'(1) << size_code;
  end
endmodule

// File: rtl/crcu_byte_step.sv
module crcu_byte_step
  import crcu_pkg::*;
(
  input  logic [CRC_W-1:0] acc,
  input  logic [7:0]       data,
  input  logic             cast,
  output logic [CRC_W-1:0] acc_next
);
  localparam int unsigned NBITS = 8;

  logic [CRC_W-1:0] poly;
  logic [CRC_W-1:0] stage [0:NBITS];

  assign poly     = cast ? POLY_CAST : POLY_STD;
  assign stage[0] = acc ^ {{(CRC_W-8){1'b0}}, data};

  genvar gi;
  generate
    for (gi = 0; gi < NBITS; gi++) begin : g_bit
      assign stage[gi+1] = stage[gi][0] ? ((stage[gi] >> 1) ^ poly)
                                        : (stage[gi] >> 1);
    end
  endgenerate

  assign acc_next = stage[NBITS];
endmodule

// File: rtl/crcu_seq.sv
module crcu_seq
  import crcu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  crcu_dec_t        dec,
  input  logic [CRC_W-1:0] acc_in,
  input  logic [XLEN-1:0]  operand,
  input  logic [CRC_W-1:0] step_out,
  output logic [CRC_W-1:0] acc_q,
  output logic [7:0]       step_byte,
  output logic             cast_q,
  output logic [IDX_W-1:0] rd_q,
  output logic             done_q,
  output logic             ill_q,
  output logic             busy
);
  crcu_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [XLEN-1:0]  opnd_q, opnd_d;
  logic [CRC_W-1:0] acc_d;
  logic [IDX_W-1:0] rd_d;
  logic             cast_d, done_d, ill_d;
  logic             accept, last;

  assign busy      = (state_q == ST_RUN);
  assign accept    = valid && !busy;
  assign last      = (cnt_q == CNT_W'(1));
  assign step_byte = opnd_q[7:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opnd_d  = opnd_q;
    acc_d   = acc_q;
    rd_d    = rd_q;
    cast_d  = cast_q;
    done_d  = 1'b0;
    ill_d   = 1'b0;
    if (accept) begin
      acc_d = acc_in;
      rd_d  = dec.rt;
      if (dec.legal) begin
        state_d = ST_RUN;
        cnt_d   = dec.nbytes;
        opnd_d  = operand;
        cast_d  = dec.cast;
      end else begin
        ill_d  = 1'b1;
        done_d = 1'b1;
      end
    end else if (busy) begin
      acc_d  = step_out;
      opnd_d = opnd_q >> 8;
      cnt_d  = cnt_q - CNT_W'(1);
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opnd_q  <= '0;
      acc_q   <= '0;
      rd_q    <= '0;
      cast_q  <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opnd_q  <= opnd_d;
      acc_q   <= acc_d;
      rd_q    <= rd_d;
      cast_q  <= cast_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
    end
  end

  // The illegal flag never appears without done.
  assert_illegal_has_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> done_q);

  // A rejected word returns the accumulator it arrived with.
  assert_illegal_keeps_acc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> (acc_q == $past(acc_in)));

  // The destination index does not move while bytes are being folded in.
  assert_rd_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_q));

  // A legal completion comes only out of a running operation.
  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ill_q) |-> $past(busy));

  // A strobe during a run cannot raise the illegal flag.
  assert_busy_strobe_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && valid) |=> !ill_q);

  // A strobe while idle always starts something.
  assert_idle_accepts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && valid) |=> (busy || done_q));
endmodule

// File: rtl/crc_exec_unit.sv
module crc_exec_unit
  import crcu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [31:0]      instr_i,
  input  logic [31:0]      acc_i,
  input  logic [XLEN-1:0]  operand_i,
  output logic [31:0]      acc_o,
  output logic [4:0]       rd_o,
  output logic             illegal_o,
  output logic             done_o
);
  logic             rst_n_sync;
  crcu_dec_t        dec;
  logic [CRC_W-1:0] acc_q, step_out;
  logic [7:0]       step_byte;
  logic             cast_q, busy;

  crcu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  crcu_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr_i),
    .dec   (dec)
  );

  crcu_byte_step u_step (
    .acc      (acc_q),
    .data     (step_byte),
    .cast     (cast_q),
    .acc_next (step_out)
  );

  crcu_seq #(.XLEN(XLEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .valid     (valid_i),
    .dec       (dec),
    .acc_in    (acc_i),
    .operand   (operand_i),
    .step_out  (step_out),
    .acc_q     (acc_q),
    .step_byte (step_byte),
    .cast_q    (cast_q),
    .rd_q      (rd_o),
    .done_q    (done_o),
    .ill_q     (illegal_o),
    .busy      (busy)
  );

  assign acc_o = acc_q;

  generate
    if (XLEN < 64) begin : g_narrow_chk
      // The eight-byte form is refused on a narrow datapath.
      assert_narrow_size3_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (valid_i && !busy && instr_i[7:6] == 2'd3) |=> illegal_o);
    end
  endgenerate
endmodule

// File: tb/crc_exec_unit_test.sv
module crc_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_w = 1'b0, valid_n = 1'b0;
  logic [31:0] instr = '0, acc_in = '0;
  logic [63:0] operand = '0;
  logic [31:0] acc_w, acc_n;
  logic [4:0]  rd_w, rd_n;
  logic        ill_w, ill_n, done_w, done_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_exec_unit #(.XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_w), .instr_i(instr),
    .acc_i(acc_in), .operand_i(operand), .acc_o(acc_w), .rd_o(rd_w),
    .illegal_o(ill_w), .done_o(done_w));

  crc_exec_unit #(.XLEN(32)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_n), .instr_i(instr),
    .acc_i(acc_in), .operand_i(operand[31:0]), .acc_o(acc_n), .rd_o(rd_n),
    .illegal_o(ill_n), .done_o(done_n));

  function automatic logic [31:0] mk(input int rs, input int rt, input int sz, input int ty);
    return 32'h7C00000F | (32'(rs) << 21) | (32'(rt) << 16) | (32'(ty) << 8) | (32'(sz) << 6);
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] a, input logic [63:0] d,
                                          input int n, input bit c);
    logic [31:0] p;
    p = c ? 32'h82F63B78 : 32'hEDB88320;
    for (int b = 0; b < n; b++) begin
      a = a ^ {24'b0, d[8*b +: 8]};
      for (int k = 0; k < 8; k++) a = a[0] ? ((a >> 1) ^ p) : (a >> 1);
    end
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Issue one operation and wait for done; returns results and latency.
  task automatic run_op(input bit narrow, input logic [31:0] ins, input logic [31:0] a,
                        input logic [63:0] d, output logic [31:0] res,
                        output logic [4:0] rd, output logic ill, output int lat);
    instr = ins; acc_in = a; operand = d;
    if (narrow) valid_n = 1'b1; else valid_w = 1'b1;
    @(negedge clk);
    valid_n = 1'b0; valid_w = 1'b0;
    lat = 0;
    while (!(narrow ? done_n : done_w) && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    res = narrow ? acc_n : acc_w;
    rd  = narrow ? rd_n : rd_w;
    ill = narrow ? ill_n : ill_w;
  endtask

  task automatic t_reset();
    chk("R10 done", 32'(done_w), 0);
    chk("R10 illegal", 32'(ill_w), 0);
    chk("R10 acc", acc_w, 0);
    chk("R10 rd", 32'(rd_w), 0);
  endtask

  task automatic t_known_answer(input bit c, input logic [31:0] exp);
    logic [31:0] r; logic [4:0] rd; logic il; int lat;
    run_op(0, mk(1, 2, 3, c), 32'hFFFFFFFF, 64'h3837363534333231, r, rd, il, lat);
    run_op(0, mk(1, 2, 0, c), r, 64'h39, r, rd, il, lat);
    chk(c ? "R4 R5 known answer castagnoli" : "R4 R5 known answer standard", ~r, exp);
  endtask

  task automatic t_sizes();
    logic [31:0] r; logic [4:0] rd; logic il; int lat;
    logic [63:0] d;
    d = 64'hA5C3_19F0_7E24_D68B;
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 4; s++) begin
        run_op(0, mk(7, 9, s, c), 32'h1234_5678, d, r, rd, il, lat);
        chk("R3 R4 R5 size/poly result", r, ref_crc(32'h1234_5678, d, 1 << s, c[0]));
        chk("R6 latency", 32'(lat), 32'(1 << s));
        chk("R6 illegal low", 32'(il), 0);
      end
    end
  endtask

  task automatic t_upper_ignored();
    logic [31:0] r1, r2; logic [4:0] rd; logic il; int lat;
    run_op(0, mk(0, 3, 1, 0), 32'hDEAD_BEEF, 64'h0000_0000_0000_4C2E, r1, rd, il, lat);
    run_op(0, mk(0, 3, 1, 0), 32'hDEAD_BEEF, 64'hFFEE_DDCC_BBAA_4C2E, r2, rd, il, lat);
    chk("R3 upper bytes ignored", r2, r1);
    chk("R3 two-byte value", r1, ref_crc(32'hDEAD_BEEF, 64'h4C2E, 2, 1'b0));
  endtask

  task automatic t_rd_index();
    logic [31:0] r1, r2; logic [4:0] rd; logic il; int lat;
    run_op(0, mk(31, 21, 2, 1), 32'h0, 64'h11223344, r1, rd, il, lat);
    chk("R2 rd index 21", 32'(rd), 21);
    run_op(0, mk(4, 0, 2, 1), 32'h0, 64'h11223344, r2, rd, il, lat);
    chk("R2 rd index 0", 32'(rd), 0);
    chk("R2 rs has no effect", r2, r1);
  endtask

  task automatic t_illegal();
    logic [31:0] r; logic [4:0] rd; logic il; int lat;
    run_op(0, mk(1, 2, 2, 0) & ~32'h1, 32'hCAFE_F00D, 64'h55, r, rd, il, lat);
    chk("R1 illegal flag low opcode bit", 32'(il), 1);
    chk("R1 accumulator unchanged", r, 32'hCAFE_F00D);
    chk("R1 illegal latency", 32'(lat), 0);
    run_op(0, mk(1, 2, 2, 0) | 32'h0000_0200, 32'h0BAD_0001, 64'h55, r, rd, il, lat);
    chk("R1 illegal flag bit 9", 32'(il), 1);
    chk("R1 accumulator unchanged bit 9", r, 32'h0BAD_0001);
    @(negedge clk);
    chk("R1 done single pulse", 32'(done_w), 0);
  endtask

  task automatic t_narrow();
    logic [31:0] r; logic [4:0] rd; logic il; int lat;
    run_op(1, mk(1, 6, 3, 0), 32'h7777_0000, 64'h0102_0304_0506_0708, r, rd, il, lat);
    chk("R7 narrow size 3 illegal", 32'(il), 1);
    chk("R7 narrow acc unchanged", r, 32'h7777_0000);
    run_op(1, mk(1, 6, 2, 1), 32'h7777_0000, 64'h0506_0708, r, rd, il, lat);
    chk("R7 narrow word ok", r, ref_crc(32'h7777_0000, 64'h0506_0708, 4, 1'b1));
    chk("R7 narrow word legal", 32'(il), 0);
    run_op(0, mk(1, 6, 3, 0), 32'h7777_0000, 64'h0102_0304_0506_0708, r, rd, il, lat);
    chk("R7 wide size 3 legal", 32'(il), 0);
  endtask

  task automatic t_busy_strobe();
    logic [63:0] d; int lat;
    d = 64'h0F1E_2D3C_4B5A_6978;
    instr = mk(2, 12, 3, 1); acc_in = 32'h0; operand = d;
    valid_w = 1'b1;
    @(negedge clk);
    valid_w = 1'b0;
    repeat (2) @(negedge clk);
    instr = mk(2, 30, 0, 0); acc_in = 32'hFFFF_FFFF; operand = 64'hFF;
    valid_w = 1'b1;
    @(negedge clk);
    valid_w = 1'b0;
    lat = 3;
    while (!done_w && lat < 20) begin @(negedge clk); lat++; end
    chk("R8 result unaffected", acc_w, ref_crc(32'h0, d, 8, 1'b1));
    chk("R8 rd unaffected", 32'(rd_w), 12);
    chk("R8 latency unaffected", 32'(lat), 8);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done_w) begin
        chk("R8 no extra done", 1, 0);
        break;
      end
    end
  endtask

  task automatic t_back_to_back();
    int lat;
    instr = mk(0, 5, 0, 0); acc_in = 32'h1111_2222; operand = 64'h9C;
    valid_w = 1'b1;
    @(negedge clk);
    valid_w = 1'b0;
    @(negedge clk);
    chk("R9 first done", 32'(done_w), 1);
    chk("R9 first result", acc_w, ref_crc(32'h1111_2222, 64'h9C, 1, 1'b0));
    instr = mk(0, 8, 1, 1); acc_in = 32'h3333_4444; operand = 64'h1F2E;
    valid_w = 1'b1;
    @(negedge clk);
    valid_w = 1'b0;
    lat = 0;
    while (!done_w && lat < 20) begin @(negedge clk); lat++; end
    chk("R9 second result", acc_w, ref_crc(32'h3333_4444, 64'h1F2E, 2, 1'b1));
    chk("R9 second latency", 32'(lat), 2);
    chk("R9 second rd", 32'(rd_w), 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_known_answer(1'b0, 32'hCBF43926);
    t_known_answer(1'b1, 32'hE3069283);
    t_sizes();
    t_upper_ignored();
    t_rd_index();
    t_illegal();
    t_narrow();
    t_busy_strobe();
    t_back_to_back();
    finish_run();
  end
endmodule